// File: doc/BRIEF.md
# Skewed SAD Element Array

This block scores every candidate displacement of an 8x8 reference block inside a 15x15 search window by the sum of absolute differences (SAD). It holds 64 processing elements, one per candidate. Reference pixels enter once, in raster order, and ripple down a register chain so that each element begins its 64-cycle accumulation one clock after its predecessor. Because the starts are skewed by exactly one cycle, one element completes on each clock, and a single 64-way selector serializes the 64 results onto one output with a candidate index.

Search pixels are not stored in the block. The skew means that on any pass cycle every element needs one of only two search pixels, so the caller drives two shared buses. One carries the pixel in the left half of the window row, and the other carries the pixel in the right half of the row above. Each element picks one of the two buses by comparing its own column offset with the current column phase. A caller streams one reference pixel and two search pixels per clock. After a fixed latency it collects 64 SAD values, ready for a downstream minimum search.

Top module: `sad_skew_array`

## Requirements
- R1: While `rst_n` is low, and after release until a pass delivers results, `sad_valid` is 0, `sad_idx` is 0 and `sad_out` is 0. Asserting `rst_n` low during a pass abandons that pass.
- R2: `start` high in an idle clock makes that clock pass cycle 0. The result for candidate k is visible with `sad_valid` high after rising edge 64+k, counting the edge that samples `start` as edge 0. `sad_valid` stays high for exactly 64 consecutive cycles, with `sad_idx` counting 0 to 63, and then falls.
- R3: Candidate k = 8*i + j, with i the row offset and j the column offset (0..7 each). Its `sad_out` equals the sum over r,c in 0..7 of |S[i+r][j+c] - R[r][c]|, where S is the search window and R the reference block.
- R4: Input schedule during pass cycle t. `ref_pix` carries R[t/8][t%8] for t < 64. `srch_lo` carries S[t/8][t%8] when t/8 <= 14. `srch_hi` carries S[t/8-1][t%8+8] when 1 <= t/8 <= 15 and t%8 <= 6. Values driven outside these slots have no effect on any result.
- R5: Each absolute difference is formed by a sign-controlled XOR inversion plus a carry-in of the sign, and it is exact for both signs. A `sad_out` is 14 bits wide, so the worst case of 64*255 = 16320 (window all 255 against reference all 0, or the reverse) is delivered without wrap.
- R6: `start` asserted while a pass is running is ignored, and the pass in progress delivers unchanged results.
- R7: Each element clears its accumulator at the first cycle of its own window, so a later pass returns results that depend only on its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when the block is idle |
| ref_pix | input | 8 | Reference pixel stream, raster order |
| srch_lo | input | 8 | Search bus for the left half of the current window row |
| srch_hi | input | 8 | Search bus for the right half of the previous window row |
| sad_valid | output | 1 | High while `sad_out` holds a fresh result |
| sad_idx | output | 6 | Candidate index 8*i + j of the current result |
| sad_out | output | 14 | Sum of absolute differences for candidate `sad_idx` |

## Verification
A pass spans input cycles 0 to 126. The result for candidate k is due after rising edge 64+k, which follows one register in the element's accumulator and one in the output selector. The bench counts pass cycles from the edge that samples `start`. It drives each cycle's pixels at the falling edge before that cycle's rising edge. It reads the outputs at the same falling edge, so the value read at falling edge 65+k is compared with candidate k. It also checks that `sad_valid` is low at falling edges 64 and 129, the cycles just before and just after the 64-cycle result burst.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_BLK   = 8;

    // Accumulator width: pixel bits plus log2 of the number of summed terms.
    function automatic int acc_bits(input int pix_w, input int blk);
        return pix_w + 2 * $clog2(blk);
    endfunction
endpackage

// File: rtl/sad_seq_ctrl.sv
module sad_seq_ctrl #(
    parameter int N_PE = 64,
    parameter int T_W  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           go,
    output logic [T_W-1:0] cur_t,
    output logic           busy
);
    localparam int LAST = 2 * N_PE - 1;

    typedef struct packed {
        logic           run;
        logic [T_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        go    = st_q.run | start;
        cur_t = st_q.run ? st_q.cnt : '0;
        if (go) begin
            if (int'(cur_t) == LAST) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.run = 1'b1;
                st_d.cnt = cur_t + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.run;
endmodule

// File: rtl/sad_pe.sv
module sad_pe #(
    parameter int PIX_W = 8,
    parameter int BLK   = 8,
    parameter int K     = 0,
    parameter int T_W   = 7,
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [T_W-1:0]   cur_t,
    input  logic [PIX_W-1:0] ref_in,
    input  logic [PIX_W-1:0] srch_lo,
    input  logic [PIX_W-1:0] srch_hi,
    output logic [PIX_W-1:0] ref_out,
    output logic [ACC_W-1:0] acc_out
);
    localparam int N_PE = BLK * BLK;
    localparam int CW   = $clog2(BLK);
    localparam int COL  = K % BLK;

    typedef struct packed {
        logic [PIX_W-1:0] ref_px;
        logic [ACC_W-1:0] acc;
    } pe_st_t;

    pe_st_t           st_d, st_q;
    logic             in_win, first, use_hi, neg;
    logic [PIX_W-1:0] pick, flip;
    logic [PIX_W:0]   diff;
    logic [ACC_W-1:0] base;

    always_comb begin
        st_d        = st_q;
        st_d.ref_px = ref_in;
        in_win = go && (int'(cur_t) >= K) && (int'(cur_t) < K + N_PE);
        first  = (int'(cur_t) == K);
        // The column phase of the pass is below this element's column exactly
        // when the needed pixel lies in the right half of the previous row.
        use_hi = (int'(cur_t[CW-1:0]) < COL);
        pick   = use_hi ? srch_hi : srch_lo;
        diff   = {1'b0, pick} - {1'b0, ref_in};
        neg    = diff[PIX_W];
        flip   = diff[PIX_W-1:0] ^ {PIX_W{neg}};
        base   = first ? '0 : st_q.acc;
        if (in_win) st_d.acc = base + ACC_W'(flip) + ACC_W'(neg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_out = st_q.ref_px;
    assign acc_out = st_q.acc;
endmodule

// File: rtl/sad_result_mux.sv
module sad_result_mux #(
    parameter int N_PE  = 64,
    parameter int ACC_W = 14,
    parameter int T_W   = 7,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [T_W-1:0]   cur_t,
    input  logic [ACC_W-1:0] accs [N_PE],
    output logic             sad_valid,
    output logic [IDX_W-1:0] sad_idx,
    output logic [ACC_W-1:0] sad_out
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] sad;
    } mux_st_t;

    mux_st_t          st_d, st_q;
    logic             capture;
    logic [IDX_W-1:0] sel;

    always_comb begin
        st_d    = st_q;
        capture = go && (int'(cur_t) >= N_PE);
        sel     = cur_t[IDX_W-1:0];
        st_d.vld = capture;
        if (capture) begin
            st_d.idx = sel;
            st_d.sad = accs[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sad_valid = st_q.vld;
    assign sad_idx   = st_q.idx;
    assign sad_out   = st_q.sad;
endmodule

// File: rtl/sad_skew_array.sv
module sad_skew_array #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W,
    parameter int BLK   = sad_pkg::DEF_BLK
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [PIX_W-1:0]                      ref_pix,
    input  logic [PIX_W-1:0]                      srch_lo,
    input  logic [PIX_W-1:0]                      srch_hi,
    output logic                                  sad_valid,
    output logic [$clog2(BLK*BLK)-1:0]            sad_idx,
    output logic [sad_pkg::acc_bits(PIX_W,BLK)-1:0] sad_out
);
    localparam int N_PE  = BLK * BLK;
    localparam int ACC_W = sad_pkg::acc_bits(PIX_W, BLK);
    localparam int IDX_W = $clog2(N_PE);
    localparam int T_W   = $clog2(2 * N_PE);

    logic             go, busy;
    logic [T_W-1:0]   cur_t;
    logic [PIX_W-1:0] ref_link [N_PE+1];
    logic [ACC_W-1:0] accs     [N_PE];

    assign ref_link[0] = ref_pix;

    sad_seq_ctrl #(.N_PE(N_PE), .T_W(T_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .go(go), .cur_t(cur_t), .busy(busy)
    );

    for (genvar k = 0; k < N_PE; k++) begin : g_pe
        sad_pe #(
            .PIX_W(PIX_W), .BLK(BLK), .K(k), .T_W(T_W), .ACC_W(ACC_W)
        ) u_pe (
            .clk(clk), .rst_n(rst_n), .go(go), .cur_t(cur_t),
            .ref_in(ref_link[k]), .srch_lo(srch_lo), .srch_hi(srch_hi),
            .ref_out(ref_link[k+1]), .acc_out(accs[k])
        );
    end

    sad_result_mux #(
        .N_PE(N_PE), .ACC_W(ACC_W), .T_W(T_W), .IDX_W(IDX_W)
    ) u_mux (
        .clk(clk), .rst_n(rst_n), .go(go), .cur_t(cur_t), .accs(accs),
        .sad_valid(sad_valid), .sad_idx(sad_idx), .sad_out(sad_out)
    );
endmodule

// File: rtl/sad_skew_array_chk.sv
module sad_skew_array_chk #(
    parameter int N_PE  = 64,
    parameter int PIX_W = 8,
    parameter int ACC_W = 14,
    parameter int IDX_W = 6,
    parameter int T_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [T_W-1:0]   cur_t,
    input logic             sad_valid,
    input logic [IDX_W-1:0] sad_idx,
    input logic [ACC_W-1:0] sad_out
);
    localparam int LAST    = 2 * N_PE - 1;
    localparam int MAX_SAD = N_PE * ((1 << PIX_W) - 1);

    a_r2_burst_opens_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sad_valid) |-> sad_idx == '0);

    a_r2_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid && $past(sad_valid) |-> sad_idx == $past(sad_idx) + 1'b1);

    a_r2_burst_closes: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid && (int'(sad_idx) == N_PE - 1) |=> !sad_valid);

    a_r2_valid_inside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> $past(busy));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid |-> int'(sad_out) <= MAX_SAD);

    a_r6_pass_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (int'(cur_t) != LAST) |=> busy && (cur_t == $past(cur_t) + 1'b1));
endmodule

bind sad_skew_array sad_skew_array_chk #(
    .N_PE(N_PE), .PIX_W(PIX_W), .ACC_W(ACC_W), .IDX_W(IDX_W), .T_W(T_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cur_t(cur_t),
    .sad_valid(sad_valid), .sad_idx(sad_idx), .sad_out(sad_out)
);

// File: tb/sad_skew_array_bench.sv
`timescale 1ns/1ps
module sad_skew_array_bench;
    localparam int NB = 8;
    localparam int NW = 15;
    localparam int NP = 64;
    localparam int VEC_N = 8;

    // Vector fields: {pattern[3:0], flags[3:0], cand0_expect[15:0], seed[31:0]}
    // flags bit0 = assert start again mid-pass; cand0_expect 16'hFFFF = model only.
    localparam logic [55:0] VEC_TAB [VEC_N] = '{
        {4'd0, 4'd0, 16'hFFFF, 32'h0000_1234},
        {4'd1, 4'd0, 16'd16320, 32'h0},
        {4'd2, 4'd0, 16'd16320, 32'h0},
        {4'd3, 4'd0, 16'hFFFF, 32'h0000_002B},
        {4'd4, 4'd0, 16'd0,     32'h0},
        {4'd5, 4'd0, 16'd64,    32'h0},
        {4'd0, 4'd1, 16'hFFFF, 32'h00C0_FFEE},
        {4'd3, 4'd1, 16'hFFFF, 32'h0000_0009}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ref_pix = '0, srch_lo = '0, srch_hi = '0;
    logic        sad_valid;
    logic [5:0]  sad_idx;
    logic [13:0] sad_out;

    int checks = 0, fails = 0;
    bit done = 0;
    int unsigned lcg;
    int ref_a [NP];
    int srch_a [NW][NW];
    int exp_a [NP];

    always #4 clk = ~clk;

    sad_skew_array u_sad_skew_array (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_pix(ref_pix),
        .srch_lo(srch_lo), .srch_hi(srch_hi),
        .sad_valid(sad_valid), .sad_idx(sad_idx), .sad_out(sad_out)
    );

    function automatic int rnd8();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) & 32'hFF);
    endfunction

    task automatic check(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic build(input int pat, input int unsigned seed);
        int oi, oj, d, s;
        lcg = seed;
        for (int r = 0; r < NW; r++)
            for (int c = 0; c < NW; c++) begin
                case (pat)
                    1: srch_a[r][c] = 255;
                    2: srch_a[r][c] = 0;
                    4: srch_a[r][c] = 77;
                    5: srch_a[r][c] = ((r + c) % 2 == 1) ? 101 : 99;
                    default: srch_a[r][c] = rnd8();
                endcase
            end
        oi = int'(seed % 8);
        oj = int'((seed / 8) % 8);
        for (int p = 0; p < NP; p++) begin
            case (pat)
                1: ref_a[p] = 0;
                2: ref_a[p] = 255;
                3: ref_a[p] = srch_a[oi + p / NB][oj + p % NB];
                4: ref_a[p] = 77;
                5: ref_a[p] = 100;
                default: ref_a[p] = rnd8();
            endcase
        end
        // Behavioural full-search model (R3)
        for (int k = 0; k < NP; k++) begin
            s = 0;
            for (int r = 0; r < NB; r++)
                for (int c = 0; c < NB; c++) begin
                    d = srch_a[k / NB + r][k % NB + c] - ref_a[r * NB + c];
                    s += (d < 0) ? -d : d;
                end
            exp_a[k] = s;
        end
    endtask

    // Drive pass cycle t per the R4 schedule; unused slots get junk.
    task automatic drive(input int t, input bit st);
        int row = t / NB, col = t % NB;
        start   = st;
        ref_pix = (t < NP) ? 8'(ref_a[t]) : 8'(rnd8());
        srch_lo = (row <= NW - 1) ? 8'(srch_a[row][col]) : 8'(rnd8());
        srch_hi = (row >= 1 && row <= NW && col <= NB - 2) ?
                  8'(srch_a[row - 1][col + NB]) : 8'(rnd8());
    endtask

    task automatic run_pass(input int pat, input int unsigned seed, input bit inject,
                            input int exp0, input string req, input int abort_at);
        build(pat, seed);
        for (int t = 0; t <= 129; t++) begin
            @(negedge clk);
            if (t == 64) check("R2", int'(sad_valid), 0, "no result before edge 64");
            if (t >= 65 && t <= 128) begin
                check("R2", int'(sad_valid), 1, "valid in burst");
                check("R2", int'(sad_idx), t - 65, "candidate index");
                check(req, int'(sad_out), exp_a[t - 65], $sformatf("sad cand %0d", t - 65));
                if (t == 65 && exp0 != 16'hFFFF)
                    check("R5", int'(sad_out), exp0, "table cand0");
            end
            if (t == 129) check("R2", int'(sad_valid), 0, "valid after burst");
            if (abort_at > 0 && t == abort_at) begin
                rst_n = 1'b0;
                start = 1'b0;
                @(negedge clk);
                check("R1", int'(sad_valid), 0, "valid in mid-pass reset");
                check("R1", int'(sad_out), 0, "sad in mid-pass reset");
                rst_n = 1'b1;
                return;
            end
            drive(t, (t == 0) || (inject && t == 30));   // R6 stray start at t=30
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(sad_valid), 0, "valid during reset");
        check("R1", int'(sad_idx), 0, "idx during reset");
        check("R1", int'(sad_out), 0, "sad during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(sad_valid), 0, "valid idle after reset");
        check("R1", int'(sad_out), 0, "sad idle after reset");

        for (int v = 0; v < VEC_N; v++) begin
            logic [55:0] e = VEC_TAB[v];
            string req = e[48] ? "R6" : ((v > 0) ? "R7" : "R3");
            run_pass(int'(e[55:52]), e[31:0], e[48], int'(e[47:32]), req, 0);
        end

        // R1: reset in the middle of a pass, then a clean pass
        run_pass(0, 32'h5151, 1'b0, 16'hFFFF, "R1", 80);
        @(negedge clk);
        check("R1", int'(sad_valid), 0, "valid after abort");
        run_pass(0, 32'h7A7A, 1'b0, 16'hFFFF, "R7", 0);
        // R4/R5: extremes in the opposite direction after a random pass
        run_pass(2, 32'h0, 1'b0, 16320, "R5", 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule